// File: doc/BRIEF.md
# Circular Failover Port Selector

This block picks the egress port for each packet of a switch with `NPORTS` ports. A request carries a fast-reroute group number. Each group names a circular order of candidate ports, and a liveness register holds one up/down bit per port. The block answers with the first live port in that circular order. When no candidate is live, it raises a no-route flag instead.

The group number first indexes a mask table. Each entry holds `2*NPORTS-1` bits. Mask bit i, counted from 0, stands for port `(i mod NPORTS)+1`, so one circular order is a run of adjacent set bits. A priority match then walks the mask bits from bit 0 upward. The first bit that is set and whose port is live chooses the result. There are only `2*NPORTS-1` match entries, and a single combinational stage resolves them all. The answer takes two cycles however many ports are down, and one request can be accepted every cycle.

Software can rewrite any mask entry and the liveness vector. A rewritten mask can clear chosen positions, which stops a port (for example a parent node in a depth-first order) from ever being picked for that group. At power-up, group address `a` holds the window that starts at port `(a mod NPORTS)+1` and covers `NPORTS` consecutive positions.

Top module: `circ_failover_sel`

## Requirements
- R1: After reset, `rsp_valid` is 0 and every liveness bit is 0 (port down). A request made before any liveness write therefore returns no-route.
- R2: A request accepted with `req_valid`=1 at one rising edge gives `rsp_valid`=1 exactly two rising edges later. A cycle without a request gives `rsp_valid`=0 two edges later. Requests may be issued on every cycle.
- R3: With the power-up masks and all ports live, group address `a` returns port `(a mod NPORTS)+1`.
- R4: `rsp_port` is the binary port number (1..NPORTS) of the lowest mask bit i that is set and whose port `(i mod NPORTS)+1` has liveness bit `(i mod NPORTS)` equal to 1. With the power-up masks this is the first live port in the circular order that starts at the group's own port and wraps past port NPORTS to port 1.
- R5: When no mask bit matches a live port (all candidates down, or the mask is all zeros), `rsp_noroute` is 1 and `rsp_port` is 0. Otherwise `rsp_noroute` is 0.
- R6: A write with `mask_we`=1 stores `mask_wdata` for group `mask_addr`. Positions written as 0 are never selected. Requests accepted at later edges use the new mask. A request accepted at the same edge as the write uses the old mask.
- R7: A write with `live_we`=1 loads `live_wdata` into the liveness register (bit p-1 is port p, 1 = up). Requests accepted at later edges use the new value. A request accepted at the same edge as the write uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mask_we | input | 1 | Write strobe for the group mask table |
| mask_addr | input | GW | Group address to write |
| mask_wdata | input | 2*NPORTS-1 | Mask value to store |
| live_we | input | 1 | Write strobe for the liveness register |
| live_wdata | input | NPORTS | New liveness vector, bit p-1 is port p |
| req_valid | input | 1 | Request strobe |
| req_group | input | GW | Group address of the request |
| rsp_valid | output | 1 | Response strobe, two cycles after the request |
| rsp_port | output | PW | Chosen port 1..NPORTS, 0 on no-route |
| rsp_noroute | output | 1 | No candidate port is live |

GW is `max(1, clog2(NGROUPS))` and PW is `clog2(NPORTS+1)`.

## Verification
The main function is tried with several liveness patterns. With all ports up, each group must start at its own port. With one port down, the answer must move to the next port in the circle. With two adjacent ports down, the search must skip more than one position, and a down last port must wrap back to port 1. With every port down, the answer must be no-route. Masks with cleared positions and an all-zero mask show that the table bits, and not only the liveness, steer the choice. Writes that coincide with a request separate old-value from new-value timing. Random back-to-back traffic with interleaved writes checks the two-cycle latency and the priority result against a bench model.

// File: rtl/circ_fo_pkg.sv
package circ_fo_pkg;

  // Port number (1-based) named by mask bit i (0-based) in a k-port switch.
  function automatic int unsigned bit_port(input int unsigned i, input int unsigned k);
    return (i % k) + 1;
  endfunction

  // Number of bits needed for a group address.
  function automatic int unsigned addr_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/circ_fo_mask_ram.sv
module circ_fo_mask_ram #(
  parameter int NPORTS  = 4,
  parameter int NGROUPS = NPORTS,
  parameter int MASKW   = 2*NPORTS-1,
  parameter int AW      = circ_fo_pkg::addr_bits(NGROUPS)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [MASKW-1:0] wdata,
  input  logic             re,
  input  logic [AW-1:0]    raddr,
  output logic [MASKW-1:0] rdata
);

  logic [MASKW-1:0] mem [NGROUPS];

  function automatic logic [MASKW-1:0] window(input int unsigned start);
    logic [MASKW-1:0] m;
    m = '0;
    for (int b = 0; b < NPORTS; b++) m[start + b] = 1'b1;
    return m;
  endfunction

  // Power-up contents: one circular window per group.
  initial begin
    for (int a = 0; a < NGROUPS; a++) mem[a] = window(a % NPORTS);
  end

  // Single write port, registered read, read-first on a collision.
  always_ff @(posedge clk) begin
    if (we && ({1'b0, waddr} < (AW+1)'(NGROUPS))) mem[waddr] <= wdata;
    if (re) begin
      if ({1'b0, raddr} < (AW+1)'(NGROUPS)) rdata <= mem[raddr];
      else                                  rdata <= '0;
    end
  end

endmodule

// File: rtl/circ_fo_prio_match.sv
module circ_fo_prio_match #(
  parameter int NPORTS = 4,
  parameter int MASKW  = 2*NPORTS-1,
  parameter int PW     = $clog2(NPORTS+1)
) (
  input  logic [MASKW-1:0]  mask,
  input  logic [NPORTS-1:0] live,
  output logic              found,
  output logic [PW-1:0]     port
);

  logic [MASKW-1:0] hit;

  // One ternary entry per mask position: its mask bit and its port's live bit.
  for (genvar i = 0; i < MASKW; i++) begin : g_entry
    assign hit[i] = mask[i] & live[i % NPORTS];
  end

  // Lowest matching entry wins.
  always_comb begin
    found = 1'b0;
    port  = '0;
    for (int i = MASKW-1; i >= 0; i--) begin
      if (hit[i]) begin
        found = 1'b1;
        port  = PW'(circ_fo_pkg::bit_port(i, NPORTS));
      end
    end
  end

endmodule

// File: rtl/circ_failover_sel.sv
module circ_failover_sel #(
  parameter int NPORTS  = 4,
  parameter int NGROUPS = NPORTS,
  localparam int MASKW  = 2*NPORTS-1,
  localparam int GW     = circ_fo_pkg::addr_bits(NGROUPS),
  localparam int PW     = $clog2(NPORTS+1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_we,
  input  logic [GW-1:0]     mask_addr,
  input  logic [MASKW-1:0]  mask_wdata,
  input  logic              live_we,
  input  logic [NPORTS-1:0] live_wdata,
  input  logic              req_valid,
  input  logic [GW-1:0]     req_group,
  output logic              rsp_valid,
  output logic [PW-1:0]     rsp_port,
  output logic              rsp_noroute
);

  logic [NPORTS-1:0] live_q;
  logic [NPORTS-1:0] live_s1;
  logic              vld_s1;
  logic [MASKW-1:0]  mask_s1;
  logic              hit_any;
  logic [PW-1:0]     hit_port;

  // Liveness register.
  always_ff @(posedge clk) begin
    if (rst)          live_q <= '0;
    else if (live_we) live_q <= live_wdata;
  end

  // Stage 1: mask lookup, liveness snapshot taken with the request.
  circ_fo_mask_ram #(
    .NPORTS (NPORTS),
    .NGROUPS(NGROUPS),
    .MASKW  (MASKW),
    .AW     (GW)
  ) u_mask (
    .clk  (clk),
    .we   (mask_we),
    .waddr(mask_addr),
    .wdata(mask_wdata),
    .re   (req_valid),
    .raddr(req_group),
    .rdata(mask_s1)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_s1  <= 1'b0;
      live_s1 <= '0;
    end else begin
      vld_s1 <= req_valid;
      if (req_valid) live_s1 <= live_q;
    end
  end

  // Stage 2: priority match.
  circ_fo_prio_match #(
    .NPORTS(NPORTS),
    .MASKW (MASKW),
    .PW    (PW)
  ) u_match (
    .mask (mask_s1),
    .live (live_s1),
    .found(hit_any),
    .port (hit_port)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid   <= 1'b0;
      rsp_port    <= '0;
      rsp_noroute <= 1'b0;
    end else begin
      rsp_valid <= vld_s1;
      if (vld_s1) begin
        rsp_port    <= hit_port;
        rsp_noroute <= ~hit_any;
      end
    end
  end

endmodule

// File: rtl/circ_fo_checker.sv
module circ_fo_checker #(
  parameter int NPORTS  = 4,
  parameter int NGROUPS = NPORTS,
  localparam int MASKW  = 2*NPORTS-1,
  localparam int GW     = circ_fo_pkg::addr_bits(NGROUPS),
  localparam int PW     = $clog2(NPORTS+1)
) (
  input logic              clk,
  input logic              rst,
  input logic              live_we,
  input logic [NPORTS-1:0] live_wdata,
  input logic              req_valid,
  input logic              rsp_valid,
  input logic [PW-1:0]     rsp_port,
  input logic              rsp_noroute
);

  // Independent track of liveness as seen by each request.
  logic [NPORTS-1:0] sh_live, cap1, cap2;
  always_ff @(posedge clk) begin
    if (rst) begin
      sh_live <= '0;
      cap1    <= '0;
      cap2    <= '0;
    end else begin
      if (live_we) sh_live <= live_wdata;
      cap1 <= sh_live;
      cap2 <= cap1;
    end
  end

  a_r1_reset_idle: assert property (@(posedge clk) $past(rst) |-> !rsp_valid);

  a_r2_latency_hit: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> ##2 rsp_valid);

  a_r2_latency_idle: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> ##2 !rsp_valid);

  a_r4_port_range: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_noroute) |-> (rsp_port >= PW'(1) && rsp_port <= PW'(NPORTS)));

  a_r4_port_live: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_noroute && rsp_port >= PW'(1) && rsp_port <= PW'(NPORTS))
      |-> cap2[rsp_port - PW'(1)]);

  a_r5_noroute_zero: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_noroute) |-> (rsp_port == '0));

  a_r5_all_down_noroute: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && cap2 == '0) |-> rsp_noroute);

endmodule

bind circ_failover_sel circ_fo_checker #(.NPORTS(NPORTS), .NGROUPS(NGROUPS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .live_we    (live_we),
  .live_wdata (live_wdata),
  .req_valid  (req_valid),
  .rsp_valid  (rsp_valid),
  .rsp_port   (rsp_port),
  .rsp_noroute(rsp_noroute)
);

// File: tb/circ_failover_sel_test.sv
module circ_failover_sel_test;
  localparam int K  = 4;
  localparam int G  = 4;
  localparam int MW = 2*K-1;
  localparam int GW = 2;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mask_we = 1'b0;
  logic [GW-1:0] mask_addr = '0;
  logic [MW-1:0] mask_wdata = '0;
  logic          live_we = 1'b0;
  logic [K-1:0]  live_wdata = '0;
  logic          req_valid = 1'b0;
  logic [GW-1:0] req_group = '0;
  logic          rsp_valid;
  logic [PW-1:0] rsp_port;
  logic          rsp_noroute;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  circ_failover_sel #(.NPORTS(K), .NGROUPS(G)) uut (
    .clk(clk), .rst(rst),
    .mask_we(mask_we), .mask_addr(mask_addr), .mask_wdata(mask_wdata),
    .live_we(live_we), .live_wdata(live_wdata),
    .req_valid(req_valid), .req_group(req_group),
    .rsp_valid(rsp_valid), .rsp_port(rsp_port), .rsp_noroute(rsp_noroute)
  );

  // Bench model state.
  logic [MW-1:0] m_mask [G];
  logic [K-1:0]  m_live;

  // Expectation pipeline: e0 issued one cycle ago, e1 two cycles ago.
  logic          e0_v, e1_v;
  logic [PW-1:0] e0_p, e1_p;
  logic          e0_n, e1_n;
  string         e0_t, e1_t;

  function automatic logic [PW:0] pick(input logic [MW-1:0] m, input logic [K-1:0] l);
    for (int i = 0; i < MW; i++)
      if (m[i] && l[i % K]) return {1'b0, PW'((i % K) + 1)};
    return {1'b1, PW'(0)};
  endfunction

  task automatic chk_resp();
    if (e1_v || rsp_valid) begin
      n_checks++;
      if (rsp_valid !== e1_v) begin
        n_fail++;
        $display("FAIL R2 (%s) rsp_valid actual=%b expected=%b", e1_t, rsp_valid, e1_v);
      end else if (rsp_port !== e1_p || rsp_noroute !== e1_n) begin
        n_fail++;
        $display("FAIL %s port/noroute actual=%0d/%b expected=%0d/%b",
                 e1_t, rsp_port, rsp_noroute, e1_p, e1_n);
      end
    end
  endtask

  task automatic cyc(input logic rv, input int g,
                     input logic mwe, input int ma, input logic [MW-1:0] md,
                     input logic lwe, input logic [K-1:0] ld, input string tag);
    logic [PW:0] r;
    @(negedge clk);
    chk_resp();
    e1_v = e0_v; e1_p = e0_p; e1_n = e0_n; e1_t = e0_t;
    req_valid = rv; req_group = GW'(g);
    mask_we = mwe; mask_addr = GW'(ma); mask_wdata = md;
    live_we = lwe; live_wdata = ld;
    r = pick(m_mask[g], m_live);
    e0_v = rv; e0_p = r[PW-1:0]; e0_n = r[PW]; e0_t = tag;
    if (mwe) m_mask[ma] = md;
    if (lwe) m_live = ld;
  endtask

  task automatic req(input int g, input string tag);
    cyc(1'b1, g, 1'b0, 0, '0, 1'b0, '0, tag);
  endtask

  task automatic setlive(input logic [K-1:0] l, input string tag);
    cyc(1'b0, 0, 1'b0, 0, '0, 1'b1, l, tag);
  endtask

  task automatic setmask(input int a, input logic [MW-1:0] m, input string tag);
    cyc(1'b0, 0, 1'b1, a, m, 1'b0, '0, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 1'b0, 0, '0, 1'b0, '0, "R2");
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int a = 0; a < G; a++) begin
      m_mask[a] = '0;
      for (int b = 0; b < K; b++) m_mask[a][(a % K) + b] = 1'b1;
    end
    m_live = '0;
    e0_v = 0; e1_v = 0; e0_p = 0; e1_p = 0; e0_n = 0; e1_n = 0; e0_t = "R1"; e1_t = "R1";

    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    n_checks++;
    if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 rsp_valid after reset actual=%b expected=0", rsp_valid);
    end

    // R1: liveness starts all down.
    req(0, "R1");
    idle(2);

    // R3: all up, each group starts at its own port.
    setlive(4'b1111, "R3");
    for (int g = 0; g < G; g++) req(g, "R3");
    idle(2);

    // R4: port 2 down -> group 1 moves on to port 3.
    setlive(4'b1101, "R4");
    req(1, "R4");
    req(0, "R4");
    // R4: ports 2 and 3 down -> port 4.
    setlive(4'b1001, "R4");
    req(1, "R4");
    // R4: port 4 down -> group 3 wraps to port 1.
    setlive(4'b0111, "R4");
    req(3, "R4");
    // R4: only port 1 up -> group 2 wraps around to it.
    setlive(4'b0001, "R4");
    req(2, "R4");
    idle(2);

    // R5: all down -> no-route for every group.
    setlive(4'b0000, "R5");
    for (int g = 0; g < G; g++) req(g, "R5");
    // R5: zero mask with all live.
    setlive(4'b1111, "R5");
    setmask(2, '0, "R5");
    req(2, "R5");
    idle(2);

    // R6: group 0 skips port 2 (bits 1 and 5 cleared).
    setmask(0, 7'b0001101, "R6");
    req(0, "R6");
    setlive(4'b1110, "R6");
    req(0, "R6");
    setlive(4'b1010, "R6");
    req(0, "R6");
    // R6: write and request at the same edge use the old mask.
    cyc(1'b1, 1, 1'b1, 1, 7'b0001000, 1'b0, '0, "R6");
    req(1, "R6");
    idle(2);

    // R7: live write at the same edge as a request uses the old value.
    setlive(4'b1111, "R7");
    cyc(1'b1, 3, 1'b0, 0, '0, 1'b1, 4'b0111, "R7");
    req(3, "R7");
    cyc(1'b1, 1, 1'b0, 0, '0, 1'b1, 4'b0000, "R7");
    req(1, "R7");
    idle(2);

    // R4 / R2: random back-to-back traffic with interleaved writes.
    for (int n = 0; n < 600; n++) begin
      logic rv, mwe, lwe;
      logic [MW-1:0] md;
      rv  = ($urandom % 4) != 0;
      mwe = ($urandom % 9) == 0;
      lwe = ($urandom % 4) == 0;
      md  = MW'($urandom) | MW'($urandom);
      cyc(rv, int'($urandom % G), mwe, int'($urandom % G), md, lwe, K'($urandom), "R4");
    end
    idle(3);

    summary();
    $finish;
  end

endmodule